// File: doc/BRIEF.md
# Loop Startup Activation Sequencer (Subscriber End)

This controller runs the subscriber-end startup of a two-wire 2B1Q digital loop. It moves through eight ordered activation states, from T0 up to T7. In each state it chooses the training signal that the local transmitter places on the line. The choices are silence, the wake tone, SN1, SN2 and SN3. The receiver reports its status on a set of flags: far-end energy present, frame sync acquired, SL2 detected, superframe marker acquired and far end operational. The sequencer advances only when these flags complete the handshake that each state waits for. Several steps of that handshake depend on the line first going quiet and then carrying signal again.

Frame-counted events use a frame strobe. Supervision time is counted in milliseconds from an external tick, so a fast tick shortens the limits in test. A start request clears every counter, records whether this is a warm or a cold start and opens state T1. The sequencer returns to T0 and pulses a failure flag when either supervision limit runs out, or when far-end energy disappears late in the sequence. Line coding, echo cancellation and equalization are handled elsewhere.

Top module: `dsl_act_seq`

## Requirements
- R1: After reset, and for as long as no start request arrives, the state code is 0, the transmit select shows silence and the failure flag is low.
- R2: The state code is a 3-bit binary number, 0 to 7, for T0 to T7. The transmit select is exactly one-hot: bit0 silence, bit1 wake tone, bit2 SN1, bit3 SN2, bit4 SN3.
- R3: In T1 the wake tone is sent for exactly 6 frame strobes, counted from the start request.
- R4: In T1, once the wake burst is over, the select shows SN1 while the SN1-enable input is high and silence while it is low. The input is followed live.
- R5: T1 moves to T2 only when two conditions hold. The wake burst must be complete. Far-end energy must also have been seen on 2 consecutive frame strobes in T1; any strobe without it restarts that count.
- R6: T2 transmits silence. T2 moves to T3 only after far-end energy has been seen absent in T2 and is then present again.
- R7: T3 moves to T4 on frame sync. T4 moves to T5 only when frame sync and SL2 detection are both high. T5 transmits SN2. T3 and T4 transmit silence.
- R8: T5 moves to T6 when the superframe marker is acquired. T6 moves to T7 when the far end reports that it is operational. T6 and T7 transmit SN3.
- R9: Counting starts at the start request. If the count of millisecond ticks reaches 5000 on a cold start, or 150 on a warm start, before T6, then on the next clock the state becomes T0 and the failure flag is high for exactly one cycle.
- R10: The same failure action follows if the count reaches 10000 on a cold start, or 150 on a warm start, before T7.
- R11: Loss of far-end energy in T5, T6 or T7 sends the state to T0 on the next clock, with a one-cycle failure pulse.
- R12: A start request in any state moves the state to T1 on the next clock. It clears the frame counters and the millisecond count, and it latches the warm/cold select. Later changes of that select have no effect until the next start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle pulse per line frame |
| msTick | input | 1 | One-cycle pulse per millisecond |
| startReq | input | 1 | Start (or restart) activation |
| warmSel | input | 1 | 1 = warm start, 0 = cold start; sampled at start |
| sn1Enable | input | 1 | Send SN1 after the wake burst |
| farSigPresent | input | 1 | Receiver sees far-end energy |
| frameSync | input | 1 | Receiver has frame sync |
| sl2Detected | input | 1 | Receiver has detected SL2 |
| sfMarker | input | 1 | Receiver has the superframe marker |
| netReady | input | 1 | Far end reports it is operational |
| txSel | output | 5 | One-hot transmit signal select |
| stateCode | output | 3 | Current activation state, binary |
| startFail | output | 1 | One-cycle startup failure pulse |

## Verification
On every cycle the embedded properties check the following:
- The transmit select stays one-hot.
- The entries into T2 and into T5 occur only with their handshake conditions present.
- A failure pulse always coincides with T0.
- Late loss of signal forces the failure path.
- The clear on a start request empties the counters and the millisecond count.

Some behaviour is shown only by the bench scenarios:
- the exact number of wake frames;
- the quiet-then-signal handshake in T2;
- the tick count at which each supervision limit fires;
- the warm select staying latched after a start;
- a restart in mid-sequence replaying the full burst.

// File: rtl/dsl_act_pkg.sv
package dsl_act_pkg;

  typedef enum logic [2:0] {
    ST_T0 = 3'd0, ST_T1 = 3'd1, ST_T2 = 3'd2, ST_T3 = 3'd3,
    ST_T4 = 3'd4, ST_T5 = 3'd5, ST_T6 = 3'd6, ST_T7 = 3'd7
  } actState_e;

  localparam int TX_W = 5;
  localparam logic [TX_W-1:0] TX_SILENT = 5'b00001;
  localparam logic [TX_W-1:0] TX_WAKE   = 5'b00010;
  localparam logic [TX_W-1:0] TX_SN1    = 5'b00100;
  localparam logic [TX_W-1:0] TX_SN2    = 5'b01000;
  localparam logic [TX_W-1:0] TX_SN3    = 5'b10000;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic inWake;
    logic inQuiet;
    logic timerRun;
    logic ntPhase;
    logic netPhase;
  } actCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic burstDone;
    logic toneValid;
    logic sawQuiet;
    logic timeUp;
  } actSts_t;

endpackage

// File: rtl/act_datapath.sv
module act_datapath
  import dsl_act_pkg::*;
#(
  parameter int WAKE_FRAMES = 6,
  parameter int TONE_FRAMES = 2,
  parameter int COLD_NT_MS  = 5000,
  parameter int COLD_NET_MS = 10000,
  parameter int WARM_MS     = 150
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStb,
  input  logic    msTick,
  input  logic    farSigPresent,
  input  logic    warmSel,
  input  actCtl_t ctl,
  output actSts_t sts
);

  localparam int COLD_MAX = (COLD_NET_MS > COLD_NT_MS) ? COLD_NET_MS : COLD_NT_MS;
  localparam int LIM_MAX  = (COLD_MAX > WARM_MS) ? COLD_MAX : WARM_MS;
  localparam int MS_W     = $clog2(LIM_MAX + 1);
  localparam int WAKE_W   = $clog2(WAKE_FRAMES + 1);
  localparam int TONE_W   = $clog2(TONE_FRAMES + 1);
  localparam logic [MS_W-1:0]   ELAPSED_TOP = MS_W'(LIM_MAX);
  localparam logic [WAKE_W-1:0] WAKE_TOP    = WAKE_W'(WAKE_FRAMES);
  localparam logic [TONE_W-1:0] TONE_TOP    = TONE_W'(TONE_FRAMES);

  logic [WAKE_W-1:0] wakeCnt;
  logic [TONE_W-1:0] toneCnt;
  logic [MS_W-1:0]   elapsed;
  logic              quietSeen;
  logic              warmQ;

  // wake burst frame counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                             wakeCnt <= '0;
    else if (ctl.clrAll)                                   wakeCnt <= '0;
    else if (ctl.inWake && frameStb && wakeCnt != WAKE_TOP) wakeCnt <= wakeCnt + 1'b1;
  end

  // consecutive far-end tone frames
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      toneCnt <= '0;
    else if (ctl.clrAll)            toneCnt <= '0;
    else if (ctl.inWake && frameStb) begin
      if (!farSigPresent)           toneCnt <= '0;
      else if (toneCnt != TONE_TOP) toneCnt <= toneCnt + 1'b1;
    end
  end

  // line went quiet while in T2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               quietSeen <= 1'b0;
    else if (ctl.clrAll)                     quietSeen <= 1'b0;
    else if (ctl.inQuiet && !farSigPresent)  quietSeen <= 1'b1;
  end

  // warm/cold latched at start, millisecond supervision count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmQ   <= 1'b0;
      elapsed <= '0;
    end else if (ctl.clrAll) begin
      warmQ   <= warmSel;
      elapsed <= '0;
    end else if (ctl.timerRun && msTick && elapsed != ELAPSED_TOP) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // one limit comparator per supervised phase: 0 = subscriber side, 1 = network side
  logic [1:0] phaseOn;
  logic [1:0] phaseHit;
  assign phaseOn = {ctl.netPhase, ctl.ntPhase};

  for (genvar g = 0; g < 2; g++) begin : g_phase
    localparam int COLD_LIM = (g == 0) ? COLD_NT_MS : COLD_NET_MS;
    logic [MS_W-1:0] lim;
    assign lim         = warmQ ? MS_W'(WARM_MS) : MS_W'(COLD_LIM);
    assign phaseHit[g] = phaseOn[g] && (elapsed >= lim);
  end

  assign sts.burstDone = (wakeCnt == WAKE_TOP);
  assign sts.toneValid = (toneCnt == TONE_TOP);
  assign sts.sawQuiet  = quietSeen;
  assign sts.timeUp    = |phaseHit;

  // R3
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sts.burstDone && !ctl.clrAll) |=> sts.burstDone);

  // R12
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrAll |=> (elapsed == '0 && !sts.burstDone && !sts.toneValid && !sts.sawQuiet));

  // R5
  tone_break_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inWake && frameStb && !farSigPresent && !ctl.clrAll) |=> !sts.toneValid);

endmodule

// File: rtl/act_control.sv
module act_control
  import dsl_act_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            sn1Enable,
  input  logic            farSigPresent,
  input  logic            frameSync,
  input  logic            sl2Detected,
  input  logic            sfMarker,
  input  logic            netReady,
  input  actSts_t         sts,
  output actCtl_t         ctl,
  output logic [TX_W-1:0] txSel,
  output logic [2:0]      stateCode,
  output logic            startFail
);

  actState_e stateQ, stateD;
  logic      failD;

  always_comb begin
    stateD = stateQ;
    failD  = 1'b0;
    if (startReq) begin
      stateD = ST_T1;
    end else if (stateQ != ST_T0 &&
                 (sts.timeUp || (stateQ >= ST_T5 && !farSigPresent))) begin
      stateD = ST_T0;
      failD  = 1'b1;
    end else begin
      unique case (stateQ)
        ST_T1: if (sts.burstDone && sts.toneValid)  stateD = ST_T2;
        ST_T2: if (sts.sawQuiet && farSigPresent)   stateD = ST_T3;
        ST_T3: if (frameSync)                       stateD = ST_T4;
        ST_T4: if (frameSync && sl2Detected)        stateD = ST_T5;
        ST_T5: if (sfMarker)                        stateD = ST_T6;
        ST_T6: if (netReady)                        stateD = ST_T7;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_T0;
      startFail <= 1'b0;
    end else begin
      stateQ    <= stateD;
      startFail <= failD;
    end
  end

  always_comb begin
    ctl.clrAll   = startReq;
    ctl.inWake   = (stateQ == ST_T1);
    ctl.inQuiet  = (stateQ == ST_T2);
    ctl.timerRun = (stateQ != ST_T0) && (stateQ != ST_T7);
    ctl.ntPhase  = (stateQ != ST_T0) && (stateQ < ST_T6);
    ctl.netPhase = (stateQ != ST_T0) && (stateQ != ST_T7);
  end

  always_comb begin
    unique case (stateQ)
      ST_T1:        txSel = !sts.burstDone ? TX_WAKE : (sn1Enable ? TX_SN1 : TX_SILENT);
      ST_T5:        txSel = TX_SN2;
      ST_T6, ST_T7: txSel = TX_SN3;
      default:      txSel = TX_SILENT;
    endcase
  end

  assign stateCode = stateQ;

  // R2
  tx_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(txSel) == 1);

  // R5
  t2_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_T2 && $past(stateQ) == ST_T1) |-> $past(sts.burstDone && sts.toneValid));

  // R7
  sn2_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_T5 && $past(stateQ) == ST_T4) |-> $past(frameSync && sl2Detected));

  // R9
  fail_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    startFail |-> (stateQ == ST_T0));

  // R11
  late_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ >= ST_T5 && !farSigPresent && !startReq) |=> (stateQ == ST_T0 && startFail));

endmodule

// File: rtl/dsl_act_seq.sv
module dsl_act_seq
  import dsl_act_pkg::*;
#(
  parameter int WAKE_FRAMES = 6,
  parameter int TONE_FRAMES = 2,
  parameter int COLD_NT_MS  = 5000,
  parameter int COLD_NET_MS = 10000,
  parameter int WARM_MS     = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       msTick,
  input  logic       startReq,
  input  logic       warmSel,
  input  logic       sn1Enable,
  input  logic       farSigPresent,
  input  logic       frameSync,
  input  logic       sl2Detected,
  input  logic       sfMarker,
  input  logic       netReady,
  output logic [4:0] txSel,
  output logic [2:0] stateCode,
  output logic       startFail
);

  actCtl_t ctl;
  actSts_t sts;

  act_control u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sn1Enable(sn1Enable),
    .farSigPresent(farSigPresent), .frameSync(frameSync), .sl2Detected(sl2Detected),
    .sfMarker(sfMarker), .netReady(netReady), .sts(sts), .ctl(ctl),
    .txSel(txSel), .stateCode(stateCode), .startFail(startFail)
  );

  act_datapath #(
    .WAKE_FRAMES(WAKE_FRAMES), .TONE_FRAMES(TONE_FRAMES),
    .COLD_NT_MS(COLD_NT_MS), .COLD_NET_MS(COLD_NET_MS), .WARM_MS(WARM_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .msTick(msTick),
    .farSigPresent(farSigPresent), .warmSel(warmSel), .ctl(ctl), .sts(sts)
  );

endmodule

// File: tb/tb_dsl_act_seq.sv
`timescale 1ns/1ps
module tb_dsl_act_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 1'b0, msTick = 1'b0, startReq = 1'b0, warmSel = 1'b0;
  logic sn1Enable = 1'b0, farSigPresent = 1'b0, frameSync = 1'b0;
  logic sl2Detected = 1'b0, sfMarker = 1'b0, netReady = 1'b0;
  logic [4:0] txSel;
  logic [2:0] stateCode;
  logic       startFail;

  always #10 clk = ~clk;  // 50 MHz

  dsl_act_seq dut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .msTick(msTick),
    .startReq(startReq), .warmSel(warmSel), .sn1Enable(sn1Enable),
    .farSigPresent(farSigPresent), .frameSync(frameSync), .sl2Detected(sl2Detected),
    .sfMarker(sfMarker), .netReady(netReady),
    .txSel(txSel), .stateCode(stateCode), .startFail(startFail)
  );

  int tests = 0, fails = 0;
  int cyc = 0, startCyc = 0, failCyc = 0, failSeen = 0, wakeSeen = 0;
  int msDiv = 4, frameCnt = 0, msCnt = 0;
  logic [4:0] prevTx = 5'b00001;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // free-running frame strobe (every 8 cycles) and millisecond tick (every msDiv cycles)
  always @(negedge clk) begin
    frameCnt = (frameCnt + 1) % 8;
    frameStb = (frameCnt == 0);
    msCnt    = (msCnt + 1) % msDiv;
    msTick   = (msCnt == 0);
  end

  // behavioural reference model
  int mSt = 0, mEl = 0, mWake = 0, mTone = 0, mQuiet = 0, mWarm = 0, mFail = 0;
  int oSt, ntL, netL;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mEl = 0; mWake = 0; mTone = 0; mQuiet = 0; mWarm = 0; mFail = 0;
    end else begin
      mFail = 0;
      oSt = mSt;
      if (startReq) begin
        mSt = 1; mEl = 0; mWake = 0; mTone = 0; mQuiet = 0; mWarm = warmSel;
      end else begin
        ntL  = mWarm ? 150 : 5000;
        netL = mWarm ? 150 : 10000;
        if (oSt != 0 && ((oSt < 6 && mEl >= ntL) || (oSt < 7 && mEl >= netL) ||
                         (oSt >= 5 && !farSigPresent))) begin
          mSt = 0; mFail = 1;
        end else begin
          if      (oSt == 1 && mWake == 6 && mTone == 2)  mSt = 2;
          else if (oSt == 2 && mQuiet && farSigPresent)   mSt = 3;
          else if (oSt == 3 && frameSync)                 mSt = 4;
          else if (oSt == 4 && frameSync && sl2Detected)  mSt = 5;
          else if (oSt == 5 && sfMarker)                  mSt = 6;
          else if (oSt == 6 && netReady)                  mSt = 7;
        end
        if (oSt != 0 && oSt != 7 && msTick && mEl < 10000) mEl++;
        if (oSt == 1 && frameStb) begin
          if (mWake < 6) mWake++;
          mTone = farSigPresent ? ((mTone < 2) ? mTone + 1 : 2) : 0;
        end
        if (oSt == 2 && !farSigPresent) mQuiet = 1;
      end
    end
  end

  function automatic int modelTx();
    if (mSt == 1) return (mWake < 6) ? 2 : (sn1Enable ? 4 : 1);
    if (mSt == 5) return 8;
    if (mSt >= 6) return 16;
    return 1;
  endfunction

  // per-cycle comparison, away from the clock edge
  always begin
    @(posedge clk);
    #2;
    cyc++;
    if (rstN) begin
      chk(stateCode == 3'(mSt), "R2 state code vs model", stateCode, mSt);
      chk(txSel == 5'(modelTx()), "R2 tx select vs model", txSel, modelTx());
      chk(startFail == mFail[0], "R9 failure flag vs model", startFail, mFail);
      if (frameStb && prevTx == 5'b00010) wakeSeen++;
      if (startFail) begin failSeen++; failCyc = cyc; end
    end
    prevTx = txSel;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitState(input int target, input int maxc, input string tag);
    int n = 0;
    while (stateCode != 3'(target) && n < maxc) begin
      @(negedge clk);
      n++;
    end
    chk(stateCode == 3'(target), tag, stateCode, target);
  endtask

  task automatic startPulse(input bit w);
    @(negedge clk);
    warmSel  = w;
    startReq = 1'b1;
    startCyc = cyc + 1;
    wakeSeen = 0;
    failSeen = 0;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic clearLine();
    farSigPresent = 0; frameSync = 0; sl2Detected = 0; sfMarker = 0; netReady = 0;
  endtask

  // drive T1..T3 handshake with far-end energy
  task automatic reachT3();
    farSigPresent = 1;
    waitState(2, 200, "R5 wake exchange done reaches T2");
    farSigPresent = 0;
    waitCyc(3);
    farSigPresent = 1;
    waitState(3, 10, "R6 quiet then signal reaches T3");
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finishRun();
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(10);
    // R1 idle after reset
    chk(stateCode == 3'd0, "R1 idle state code", stateCode, 0);
    chk(txSel == 5'b00001, "R1 idle tx silence", txSel, 1);
    chk(startFail == 1'b0, "R1 no failure at idle", startFail, 0);

    // run A: cold, SN1 enabled, far end silent at first
    sn1Enable = 1;
    startPulse(0);
    chk(txSel == 5'b00010, "R3 wake tone right after start", txSel, 2);
    waitCyc(70);
    chk(wakeSeen == 6, "R3 wake burst frame count", wakeSeen, 6);
    chk(stateCode == 3'd1, "R5 stays in T1 without far tone", stateCode, 1);
    chk(txSel == 5'b00100, "R4 SN1 after burst", txSel, 4);
    sn1Enable = 0;
    waitCyc(2);
    chk(txSel == 5'b00001, "R4 silence after burst when SN1 disabled", txSel, 1);
    farSigPresent = 1;
    waitState(2, 100, "R5 T2 after far tone validated");
    chk(txSel == 5'b00001, "R6 silence in T2", txSel, 1);
    waitCyc(30);
    chk(stateCode == 3'd2, "R6 T2 holds without quiet interval", stateCode, 2);
    farSigPresent = 0;
    waitCyc(3);
    farSigPresent = 1;
    waitState(3, 10, "R6 T3 after quiet then signal");
    sl2Detected = 1;
    waitCyc(30);
    chk(stateCode == 3'd3, "R7 SL2 without frame sync holds T3", stateCode, 3);
    frameSync = 1;
    waitState(5, 10, "R7 T5 after sync and SL2");
    chk(txSel == 5'b01000, "R7 SN2 sent in T5", txSel, 8);
    sfMarker = 1;
    waitState(6, 10, "R8 T6 on superframe marker");
    chk(txSel == 5'b10000, "R8 SN3 sent in T6", txSel, 16);
    netReady = 1;
    waitState(7, 10, "R8 T7 on far end operational");
    farSigPresent = 0;
    waitCyc(3);
    chk(failSeen == 1, "R11 one failure pulse on late loss", failSeen, 1);
    chk(stateCode == 3'd0, "R11 back to T0 on late loss", stateCode, 0);
    clearLine();

    // run B: warm start timeout, select changed after start
    msDiv = 1;
    startPulse(1);
    warmSel = 0;
    waitCyc(200);
    chk(failSeen == 1, "R9 warm timeout single pulse", failSeen, 1);
    chk(failCyc - startCyc == 151, "R12 warm limit latched at start", failCyc - startCyc, 151);

    // run C: cold subscriber-side limit, stall in T3
    startPulse(0);
    reachT3();
    waitCyc(5200);
    chk(failSeen == 1, "R9 cold subscriber limit fires once", failSeen, 1);
    chk(failCyc - startCyc == 5001, "R9 cold subscriber limit timing", failCyc - startCyc, 5001);
    clearLine();

    // run D: cold network-side limit, stall in T6
    startPulse(0);
    reachT3();
    frameSync = 1; sl2Detected = 1; sfMarker = 1;
    waitState(6, 20, "R8 T6 reached for network limit run");
    waitCyc(10200);
    chk(failSeen == 1, "R10 cold network limit fires once", failSeen, 1);
    chk(failCyc - startCyc == 10001, "R10 cold network limit timing", failCyc - startCyc, 10001);
    clearLine();

    // run E: restart in mid-sequence
    msDiv = 4;
    startPulse(0);
    reachT3();
    frameSync = 1;
    waitState(4, 10, "R7 T4 on frame sync");
    clearLine();
    startPulse(1);
    chk(stateCode == 3'd1, "R12 restart returns to T1", stateCode, 1);
    chk(txSel == 5'b00010, "R12 restart replays wake tone", txSel, 2);
    waitCyc(70);
    chk(wakeSeen == 6, "R12 restart clears wake counter", wakeSeen, 6);
    waitCyc(700);
    chk(failSeen == 1, "R12 warm select latched on restart", failSeen, 1);

    finishRun();
  end

endmodule